// File: doc/BRIEF.md
# Backtracking SAT Search Engine

This block decides satisfiability of one small Boolean formula in conjunctive normal form. Each variable has its own small state machine. The machine holds the variable's three-valued assignment: unassigned, tried at 0, or tried at 1. A combinational evaluator grades the whole formula under the current partial assignment as satisfied, conflicting or undetermined, and returns that verdict to every variable machine in the same cycle. A search token moves through the chain of variable machines in index order. The chain performs a depth-first search that tries 0 before 1 and backtracks chronologically.

The formula is presented on two mask buses, one marking positive literals and one marking negative literals for each clause. A start pulse captures the masks and begins the search. When the search ends, `done` rises and `is_sat` gives the outcome. A satisfying partial assignment can be read on `asg_known` and `asg_value`. The block advances one search step per clock.

Top module: `sat_search_engine`

## Requirements
- R1: While reset is low, and until the first accepted start, `done`, `is_sat`, `asg_known` and `asg_value` are all zero.
- R2: For each variable v, `asg_known[v]`=0 means unassigned. In that case `asg_value[v]` reads 0. When `asg_known[v]`=1, `asg_value[v]` is the assigned truth value.
- R3: Clause c uses bits c*NVARS+v of `pos_masks` (literal x_v) and `neg_masks` (literal not x_v). A clause whose two masks are both zero is ignored. The verdict is CONFLICT if some non-ignored clause has every literal assigned and false. It is SAT if every non-ignored clause has a true literal. Otherwise it is UNDETERMINED.
- R4: A start accepted while idle or finished captures both mask buses. Changes on the mask buses after that point do not affect the running search.
- R5: The block makes one verdict per clock. If the search makes S verdicts, `done` is first seen high S rising edges after the edge that accepts start.
- R6: Variables are decided in index order, and value 0 is tried before value 1. A CONFLICT flips the deepest variable still at 0 to 1 and unassigns every deeper variable. `asg_known` is therefore always a contiguous run of ones starting at bit 0.
- R7: On a SAT verdict, the search stops with `done`=1 and `is_sat`=1. The reported partial assignment makes every non-ignored clause true.
- R8: A CONFLICT with no variable left at 0 ends the search with `done`=1, `is_sat`=0 and `asg_known`=0.
- R9: A start pulse during a running search is ignored.
- R10: After the search ends, `done`, `is_sat` and the assignment hold until the next start. A start then runs a new search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a search; ignored while one runs |
| pos_masks | input | NCLAUSES*NVARS | Positive-literal mask per clause |
| neg_masks | input | NCLAUSES*NVARS | Negative-literal mask per clause |
| done | output | 1 | Search finished |
| is_sat | output | 1 | Formula satisfiable (valid with done) |
| asg_known | output | NVARS | Variable assigned flags |
| asg_value | output | NVARS | Assigned values, 0 where unassigned |

## Verification
The bench compares the design against an independent model of the search. The model predicts the outcome, the exact partial assignment and the exact number of steps for each formula. A design that backtracked to the wrong depth, tried 1 before 0, or spent an extra cycle per step would differ in the assignment or in the cycle count.

The test formulas are chosen to hit specific corner cases:
- a formula with only ignored clauses, which is satisfied with nothing assigned and after one step;
- a single-variable contradiction;
- an exhaustive unsatisfiable three-variable formula that walks the whole backtrack tree back past the first variable;
- an eight-variable implication chain that has to reach the last variable.

Directed runs change the mask buses and pulse start in the middle of a search. A design that failed to latch the masks, or that restarted on start, would end with a different result or step count.

// File: rtl/sat_pkg.sv
// Shared types of the SAT search engine: deduction verdicts, per-variable
// search states and controller states.
package sat_pkg;
    typedef enum logic [1:0] {
        DED_UNDET    = 2'd0,
        DED_SAT      = 2'd1,
        DED_CONFLICT = 2'd2
    } ded_t;

    typedef enum logic [1:0] {
        VS_FREE = 2'd0,
        VS_TRY0 = 2'd1,
        VS_TRY1 = 2'd2
    } var_state_t;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_RUN  = 2'd1,
        CS_DONE = 2'd2
    } ctrl_state_t;
endpackage

// File: rtl/sat_deduce.sv
// Three-valued formula evaluator. It grades every clause under the current
// partial assignment and merges the clause results into one verdict.
// Assumes: value bits are only meaningful where known is set; a clause
// with no literals is ignored.
module sat_deduce
    import sat_pkg::*;
#(
    parameter int NVARS    = 8,
    parameter int NCLAUSES = 16
) (
    input  logic [NCLAUSES*NVARS-1:0] pos_q,
    input  logic [NCLAUSES*NVARS-1:0] neg_q,
    input  logic [NVARS-1:0]          known,
    input  logic [NVARS-1:0]          value,
    output ded_t                      verdict
);
    logic [NCLAUSES-1:0] cl_true;
    logic [NCLAUSES-1:0] cl_false;

    for (genvar c = 0; c < NCLAUSES; c++) begin : g_clause
        logic [NVARS-1:0] p, n;
        logic             used, hit, open;
        assign p    = pos_q[c*NVARS +: NVARS];
        assign n    = neg_q[c*NVARS +: NVARS];
        assign used = |(p | n);
        assign hit  = |((p & known & value) | (n & known & ~value));
        assign open = |((p | n) & ~known);
        assign cl_true[c]  = ~used | hit;
        assign cl_false[c] = used & ~hit & ~open;
    end

    // Merge clause grades: a false clause dominates, then all-true.
    always_comb begin
        if (|cl_false)     verdict = DED_CONFLICT;
        else if (&cl_true) verdict = DED_SAT;
        else               verdict = DED_UNDET;
    end
endmodule

// File: rtl/sat_var_fsm.sv
// One variable machine of the search chain. It holds the variable's
// three-valued state and the search token. On UNDETERMINED, a token from
// the previous link makes it try 0. On CONFLICT, the deepest machine at 0
// flips to 1 and keeps the token, and every machine past it unassigns.
// Assumes: deeper_try0 reports whether any later variable is at 0.
module sat_var_fsm
    import sat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  ded_t verdict,
    input  logic tok_in,
    input  logic deeper_try0,
    output logic tok_q,
    output logic is_try0,
    output logic known,
    output logic value
);
    var_state_t st_q, st_d;
    logic       tok_d;

    // Next state from the broadcast verdict and the neighbour links.
    always_comb begin
        st_d  = st_q;
        tok_d = tok_q;
        if (step) begin
            if (verdict == DED_UNDET) begin
                if (tok_in) begin
                    st_d  = VS_TRY0;
                    tok_d = 1'b1;
                end else if (tok_q) begin
                    tok_d = 1'b0;
                end
            end else if (verdict == DED_CONFLICT && st_q != VS_FREE && !deeper_try0) begin
                if (st_q == VS_TRY0) begin
                    st_d  = VS_TRY1;
                    tok_d = 1'b1;
                end else begin
                    st_d  = VS_FREE;
                    tok_d = 1'b0;
                end
            end
        end
    end

    // State register with synchronous reset and search clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            st_q  <= VS_FREE;
            tok_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            tok_q <= tok_d;
        end
    end

    assign is_try0 = (st_q == VS_TRY0);
    assign known   = (st_q != VS_FREE);
    assign value   = (st_q == VS_TRY1);
endmodule

// File: rtl/sat_ctrl.sv
// Global controller. It accepts start, holds the root token until the
// first variable is entered, and ends the search on SAT or exhaustion.
// Assumes: any_try0 is the OR of all variable machines' "at 0" flags.
module sat_ctrl
    import sat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  ded_t verdict,
    input  logic any_try0,
    output logic load,
    output logic running,
    output logic root_tok,
    output logic done,
    output logic is_sat
);
    ctrl_state_t cs_q;

    assign running = (cs_q == CS_RUN);
    assign load    = start && (cs_q != CS_RUN);
    assign done    = (cs_q == CS_DONE);

    // Controller sequence, root token and result flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q     <= CS_IDLE;
            root_tok <= 1'b0;
            is_sat   <= 1'b0;
        end else if (load) begin
            cs_q     <= CS_RUN;
            root_tok <= 1'b1;
            is_sat   <= 1'b0;
        end else if (running) begin
            if (verdict == DED_UNDET) begin
                root_tok <= 1'b0;
            end else if (verdict == DED_SAT) begin
                cs_q   <= CS_DONE;
                is_sat <= 1'b1;
            end else if (!any_try0) begin
                cs_q     <= CS_DONE;
                root_tok <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sat_search_engine.sv
// Top of the SAT search engine. It latches the clause masks on start,
// chains the variable machines and broadcasts the verdict to all of them.
// Assumes: masks are valid in the cycle start is accepted.
module sat_search_engine
    import sat_pkg::*;
#(
    parameter int NVARS    = 8,
    parameter int NCLAUSES = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [NCLAUSES*NVARS-1:0] pos_masks,
    input  logic [NCLAUSES*NVARS-1:0] neg_masks,
    output logic                      done,
    output logic                      is_sat,
    output logic [NVARS-1:0]          asg_known,
    output logic [NVARS-1:0]          asg_value
);
    localparam int MASK_W = NCLAUSES * NVARS;

    logic [MASK_W-1:0] pos_q, neg_q;
    logic [NVARS-1:0]  tok_vec, try0_vec;
    logic              load, running, root_tok;
    ded_t              verdict;

    // Capture the formula when a search is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            neg_q <= '0;
        end else if (load) begin
            pos_q <= pos_masks;
            neg_q <= neg_masks;
        end
    end

    sat_deduce #(.NVARS(NVARS), .NCLAUSES(NCLAUSES)) deduce_i (
        .pos_q   (pos_q),
        .neg_q   (neg_q),
        .known   (asg_known),
        .value   (asg_value),
        .verdict (verdict)
    );

    sat_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .verdict  (verdict),
        .any_try0 (|try0_vec),
        .load     (load),
        .running  (running),
        .root_tok (root_tok),
        .done     (done),
        .is_sat   (is_sat)
    );

    for (genvar v = 0; v < NVARS; v++) begin : g_var
        logic prev_tok, deeper;
        if (v == 0) begin : g_first
            assign prev_tok = root_tok;
        end else begin : g_link
            assign prev_tok = tok_vec[v-1];
        end
        if (v == NVARS-1) begin : g_last
            assign deeper = 1'b0;
        end else begin : g_mid
            assign deeper = |try0_vec[NVARS-1:v+1];
        end
        sat_var_fsm var_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .clear       (load),
            .step        (running),
            .verdict     (verdict),
            .tok_in      (prev_tok),
            .deeper_try0 (deeper),
            .tok_q       (tok_vec[v]),
            .is_try0     (try0_vec[v]),
            .known       (asg_known[v]),
            .value       (asg_value[v])
        );
    end
endmodule

// File: rtl/sat_search_chk.sv
// Property checker for the SAT search engine, attached by bind.
module sat_search_chk #(
    parameter int NVARS    = 8,
    parameter int NCLAUSES = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start,
    input logic                      running,
    input logic                      root_tok,
    input logic [NVARS-1:0]          tok_vec,
    input logic [NCLAUSES*NVARS-1:0] pos_q,
    input logic [NCLAUSES*NVARS-1:0] neg_q,
    input logic                      done,
    input logic                      is_sat,
    input logic [NVARS-1:0]          asg_known,
    input logic [NVARS-1:0]          asg_value
);
    // R5
    token_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> $countones({tok_vec, root_tok}) == 1);

    // R6
    known_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (asg_known & (asg_known + 1'b1)) == '0);

    // R2
    free_value_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (asg_value & ~asg_known) == '0);

    // R8
    unsat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !is_sat) |-> asg_known == '0);

    // R7
    sat_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_sat |-> done);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(is_sat) && $stable(asg_known) && $stable(asg_value)));

    // R4
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> ($stable(pos_q) && $stable(neg_q)));
endmodule

bind sat_search_engine sat_search_chk #(.NVARS(NVARS), .NCLAUSES(NCLAUSES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .running   (running),
    .root_tok  (root_tok),
    .tok_vec   (tok_vec),
    .pos_q     (pos_q),
    .neg_q     (neg_q),
    .done      (done),
    .is_sat    (is_sat),
    .asg_known (asg_known),
    .asg_value (asg_value)
);

// File: tb/sat_search_engine_tb_top.sv
`timescale 1ns/1ps
module sat_search_engine_tb_top;
    localparam int NV = 8;
    localparam int NC = 16;
    localparam int NI = 6;
    localparam int CPI = 8;

    // Per instance, 8 clauses as {pos[7:0], neg[7:0]}; remaining clauses empty.
    localparam logic [15:0] TBL [NI*CPI] = '{
        16'h0100, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
        16'h0100, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
        16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
        16'h0100, 16'h0201, 16'h0402, 16'h0804, 16'h1008, 16'h2010, 16'h4020, 16'h8040,
        16'h0700, 16'h0601, 16'h0502, 16'h0403, 16'h0304, 16'h0205, 16'h0106, 16'h0007,
        16'h0502, 16'h0801, 16'h100C, 16'h2010, 16'h0060, 16'hC001, 16'h0280, 16'h8820
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [NC*NV-1:0] pos_m = '0;
    logic [NC*NV-1:0] neg_m = '0;
    logic             done, is_sat;
    logic [NV-1:0]    asg_known, asg_value;
    int               n_tests = 0;
    int               n_fail = 0;

    always #4 clk = ~clk;

    sat_search_engine #(.NVARS(NV), .NCLAUSES(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pos_masks(pos_m), .neg_masks(neg_m),
        .done(done), .is_sat(is_sat),
        .asg_known(asg_known), .asg_value(asg_value)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load_inst(int k);
        pos_m = '0;
        neg_m = '0;
        for (int c = 0; c < CPI; c++) begin
            pos_m[c*NV +: NV] = TBL[k*CPI + c][15:8];
            neg_m[c*NV +: NV] = TBL[k*CPI + c][7:0];
        end
    endtask

    // Three-valued grade of the mask buses: 0 undetermined, 1 sat, 2 conflict.
    function automatic int eval3(logic [NV-1:0] kn, logic [NV-1:0] vl);
        bit all_true = 1'b1;
        for (int c = 0; c < NC; c++) begin
            logic [NV-1:0] p, n;
            bit t, o;
            p = pos_m[c*NV +: NV];
            n = neg_m[c*NV +: NV];
            if ((p | n) == '0) continue;
            t = |((p & kn & vl) | (n & kn & ~vl));
            o = |((p | n) & ~kn);
            if (!t && !o) return 2;
            if (!t) all_true = 1'b0;
        end
        return all_true ? 1 : 0;
    endfunction

    // Depth-first model: index order, 0 before 1, chronological backtrack.
    task automatic ref_run(output bit sat, output int steps,
                           output logic [NV-1:0] kn, output logic [NV-1:0] vl);
        int st[NV];
        int h = -1;
        bit fin = 1'b0;
        for (int v = 0; v < NV; v++) st[v] = 0;
        steps = 0;
        sat = 1'b0;
        while (!fin && steps < 10000) begin
            int r;
            for (int v = 0; v < NV; v++) begin
                kn[v] = (st[v] != 0);
                vl[v] = (st[v] == 2);
            end
            steps++;
            r = eval3(kn, vl);
            if (r == 1) begin
                sat = 1'b1;
                fin = 1'b1;
            end else if (r == 0) begin
                h++;
                st[h] = 1;
            end else begin
                bit flipped = 1'b0;
                while (!flipped && !fin) begin
                    if (h < 0) fin = 1'b1;
                    else if (st[h] == 1) begin
                        st[h] = 2;
                        flipped = 1'b1;
                    end else begin
                        st[h] = 0;
                        h--;
                    end
                end
            end
        end
        for (int v = 0; v < NV; v++) begin
            kn[v] = (st[v] != 0);
            vl[v] = (st[v] == 2);
        end
    endtask

    // mode 0: plain; 1: masks changed after acceptance; 2: extra start mid-run.
    task automatic do_search(int mode, output int cyc);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (mode == 1 && cyc == 1) load_inst(2);
            if (mode == 2 && cyc == 3) start = 1'b1;
            if (mode == 2 && cyc == 4) start = 1'b0;
        end
    endtask

    task automatic check_outcome(string tag, bit rsat, int rsteps,
                                 logic [NV-1:0] rkn, logic [NV-1:0] rvl, int cyc);
        chk(rsat ? "R7" : "R8", {tag, " done"}, done, 1);
        chk(rsat ? "R7" : "R8", {tag, " is_sat"}, is_sat, rsat);
        chk("R5", {tag, " step count"}, cyc, rsteps);
        chk("R6", {tag, " known"}, asg_known, rkn);
        chk("R2", {tag, " value"}, asg_value, rvl);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        bit            rsat;
        int            rsteps, cyc;
        logic [NV-1:0] rkn, rvl;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset done", done, 0);
        chk("R1", "reset is_sat", is_sat, 0);
        chk("R1", "reset known", asg_known, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle done", done, 0);

        // Table walk: each formula checked against the model (R3 verdicts drive all).
        for (int k = 0; k < NI; k++) begin
            load_inst(k);
            ref_run(rsat, rsteps, rkn, rvl);
            do_search(0, cyc);
            check_outcome($sformatf("inst%0d", k), rsat, rsteps, rkn, rvl, cyc);
            if (rsat) chk("R3", $sformatf("inst%0d clauses true", k), eval3(asg_known, asg_value), 1);
        end

        // R7 R8: known outcomes of chosen formulas
        load_inst(2); ref_run(rsat, rsteps, rkn, rvl);
        chk("R3", "empty formula sat in one step", rsteps * 2 + rsat, 3);
        load_inst(4); ref_run(rsat, rsteps, rkn, rvl);
        chk("R8", "exhaustive formula unsat", rsat, 0);

        // R4: mask buses changed after start; formula 4 still governs
        load_inst(4);
        ref_run(rsat, rsteps, rkn, rvl);
        do_search(1, cyc);
        check_outcome("R4 masks latched", rsat, rsteps, rkn, rvl, cyc);

        // R9: start pulsed mid-search is ignored
        load_inst(5);
        ref_run(rsat, rsteps, rkn, rvl);
        do_search(2, cyc);
        check_outcome("R9 start ignored", rsat, rsteps, rkn, rvl, cyc);

        // R10: result holds without start, then a new start reruns
        repeat (5) @(negedge clk);
        chk("R10", "held done", done, 1);
        chk("R10", "held is_sat", is_sat, rsat);
        chk("R10", "held known", asg_known, rkn);
        chk("R10", "held value", asg_value, rvl);
        load_inst(0);
        ref_run(rsat, rsteps, rkn, rvl);
        do_search(0, cyc);
        check_outcome("R10 rerun", rsat, rsteps, rkn, rvl, cyc);

        // R1: reset during a search clears everything
        load_inst(4);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "mid-run reset done", done, 0);
        chk("R1", "mid-run reset known", asg_known, 0);
        chk("R1", "mid-run reset value", asg_value, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "no search after reset", asg_known, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule